// File: doc/BRIEF.md
# Strap Latch and Clock Mode Decoder

This block fixes the operating mode of a multi-output clock generator. On the first clock edge after reset is released it captures three strap inputs: a two-bit system-clock frequency code, a DDR frequency select and a PCIe frequency select. It raises a one-cycle valid pulse at that edge. After that the straps are ignored. The captured frequency code seeds a register value that later writes from the register block may replace. The DDR and PCIe selects stay as captured until the next reset.

The block also holds the spread-spectrum code for two domains. One domain covers the system and DDR clocks. The other covers PCIe. Register writes load these codes. Each domain has its own lock. Once a domain holds a code that spreads, a later write that asks for no spread is dropped, so the only way back to no spread is reset. The PCIe code the block drives out is zero whenever PCIe runs at 125 MHz.

Top module: `clk_mode_decode`

## Requirements
- R1: While reset is asserted the outputs read sampleValid=0, sysFreqCode=2'b11, ddrSel=1, pcieSel=1, sysSpreadCode=3'b000 and pcieSpreadCode=2'b00. These are the values an undriven strap pin with a pull-up would give.
- R2: On the first rising clock edge after rstN goes high, strapFs, strapDdrSel and strapPcieSel are captured onto sysFreqCode, ddrSel and pcieSel. sampleValid is 1 for the cycle after that edge only.
- R3: After capture, changes on the strap inputs have no effect on sysFreqCode, ddrSel or pcieSel.
- R4: sysFreqCode uses this encoding: 00 is 66.66 MHz, 01 is 100 MHz, 10 is 80 MHz and 11 is 83.33 MHz. A pulse on freqWe after capture loads freqData on the next edge.
- R5: If freqWe is high on the capture edge, the strap value wins and freqData is discarded.
- R6: ddrSel=0 selects 100 MHz DDR and ddrSel=1 selects 66.66 MHz. pcieSel=0 selects 125 MHz PCIe and pcieSel=1 selects 100 MHz.
- R7: sysSpreadCode takes these down-spread values: 000 is none, 001 is 0.5%, 010 is 0.75%, 011 is 0.25%, 100 is 1%, 101 is 1.25%, 110 is 1.5% and 111 is 2%. While it is 000, a sysSpreadWe pulse loads any value.
- R8: Once sysSpreadCode is nonzero, a write of 000 leaves it unchanged. A write of any other nonzero value loads that value.
- R9: The stored PCIe spread code uses 01 for 0.5% and 10 for 0.75% down spread, and 00 or 11 for no spread. Once 01 or 10 is stored, a write of 00 or 11 is dropped, while a write of 01 or 10 loads.
- R10: pcieSpreadCode equals the stored PCIe code when pcieSel=1. It is 00 when pcieSel=0.
- R11: Reset clears both spread codes and releases both locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapFs | input | 2 | System frequency strap |
| strapDdrSel | input | 1 | DDR frequency strap |
| strapPcieSel | input | 1 | PCIe frequency strap |
| freqWe | input | 1 | Frequency override write strobe |
| freqData | input | 2 | Frequency override value |
| sysSpreadWe | input | 1 | System/DDR spread write strobe |
| sysSpreadData | input | 3 | System/DDR spread value |
| pcieSpreadWe | input | 1 | PCIe spread write strobe |
| pcieSpreadData | input | 2 | PCIe spread value |
| sampleValid | output | 1 | One-cycle pulse after strap capture |
| sysFreqCode | output | 2 | Active system clock frequency code |
| ddrSel | output | 1 | Latched DDR select |
| pcieSel | output | 1 | Latched PCIe select |
| sysSpreadCode | output | 3 | System/DDR spread code |
| pcieSpreadCode | output | 2 | Effective PCIe spread code |

## Verification
The lock rules depend on history, so the outcome of one write depends on the write before it. From a fresh reset, the bench applies every ordered pair of codes in each spread domain, and it does the PCIe pairs under both PCIe frequencies. Each pair needs its own reset, since that is the only way a locked domain can leave spread. The capture-edge collision is the hardest case to reach from the ports. The bench reaches it by holding freqWe with a conflicting value across the release of reset, so that the write and the capture fall on the same edge.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  localparam int FREQ_W   = 2;
  localparam int SYS_SS_W = 3;
  localparam int PCIE_SS_W = 2;

  localparam logic [FREQ_W-1:0]    FREQ_RESET   = '1;
  localparam logic [SYS_SS_W-1:0]  SYS_SS_OFF   = '0;
  localparam logic [PCIE_SS_W-1:0] PCIE_SS_OFF0 = 2'b00;
  localparam logic [PCIE_SS_W-1:0] PCIE_SS_OFF1 = 2'b11;

  typedef struct packed {
    logic capture;
    logic freqWr;
    logic sysSpreadWr;
    logic pcieSpreadWr;
  } cfgStrobe_t;

  function automatic logic pcieSpreads(input logic [PCIE_SS_W-1:0] code);
    return (code != PCIE_SS_OFF0) && (code != PCIE_SS_OFF1);
  endfunction
endpackage

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 freqWe,
  input  logic                 sysSpreadWe,
  input  logic [SYS_SS_W-1:0]  sysSpreadData,
  input  logic                 pcieSpreadWe,
  input  logic [PCIE_SS_W-1:0] pcieSpreadData,
  input  logic                 sysLocked,
  input  logic                 pcieLocked,
  output cfgStrobe_t           stb,
  output logic                 sampleValid
);
  logic capturedQ;
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capturedQ <= 1'b0;
      validQ    <= 1'b0;
    end else begin
      capturedQ <= 1'b1;
      validQ    <= !capturedQ;
    end
  end

  always_comb begin
    stb.capture      = !capturedQ;
    stb.freqWr       = freqWe && capturedQ;
    stb.sysSpreadWr  = sysSpreadWe && !(sysLocked && (sysSpreadData == SYS_SS_OFF));
    stb.pcieSpreadWr = pcieSpreadWe && !(pcieLocked && !pcieSpreads(pcieSpreadData));
  end

  assign sampleValid = validQ;

  // R2: the valid pulse lasts one cycle
  p_valid_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R5: the override strobe never coincides with capture
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !stb.freqWr);
endmodule

// File: rtl/clk_mode_dp.sv
module clk_mode_dp
  import clk_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           stb,
  input  logic [FREQ_W-1:0]    strapFs,
  input  logic                 strapDdrSel,
  input  logic                 strapPcieSel,
  input  logic [FREQ_W-1:0]    freqData,
  input  logic [SYS_SS_W-1:0]  sysSpreadData,
  input  logic [PCIE_SS_W-1:0] pcieSpreadData,
  output logic                 sysLocked,
  output logic                 pcieLocked,
  output logic [FREQ_W-1:0]    sysFreqCode,
  output logic                 ddrSel,
  output logic                 pcieSel,
  output logic [SYS_SS_W-1:0]  sysSpreadCode,
  output logic [PCIE_SS_W-1:0] pcieSpreadCode
);
  logic [FREQ_W-1:0]    freqQ;
  logic                 ddrQ;
  logic                 pcieQ;
  logic [SYS_SS_W-1:0]  sysSsQ;
  logic [PCIE_SS_W-1:0] pcieSsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqQ <= FREQ_RESET;
      ddrQ  <= 1'b1;
      pcieQ <= 1'b1;
    end else if (stb.capture) begin
      freqQ <= strapFs;
      ddrQ  <= strapDdrSel;
      pcieQ <= strapPcieSel;
    end else if (stb.freqWr) begin
      freqQ <= freqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysSsQ  <= SYS_SS_OFF;
      pcieSsQ <= PCIE_SS_OFF0;
    end else begin
      if (stb.sysSpreadWr)  sysSsQ  <= sysSpreadData;
      if (stb.pcieSpreadWr) pcieSsQ <= pcieSpreadData;
    end
  end

  assign sysLocked      = (sysSsQ != SYS_SS_OFF);
  assign pcieLocked     = pcieSpreads(pcieSsQ);
  assign sysFreqCode    = freqQ;
  assign ddrSel         = ddrQ;
  assign pcieSel        = pcieQ;
  assign sysSpreadCode  = sysSsQ;
  assign pcieSpreadCode = pcieQ ? pcieSsQ : PCIE_SS_OFF0;

  // R3: latched selects hold once captured
  p_straps_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(ddrSel) && $stable(pcieSel));

  // R4: frequency code changes only on capture or override
  p_freq_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capture && !stb.freqWr) |=> $stable(sysFreqCode));

  // R8: system spread never returns to none before reset
  p_sys_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sysSpreadCode != SYS_SS_OFF) |=> (sysSpreadCode != SYS_SS_OFF));

  // R9: stored PCIe spread never leaves a spreading code before reset
  p_pcie_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcieLocked |=> pcieLocked);
endmodule

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
  import clk_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FREQ_W-1:0]    strapFs,
  input  logic                 strapDdrSel,
  input  logic                 strapPcieSel,
  input  logic                 freqWe,
  input  logic [FREQ_W-1:0]    freqData,
  input  logic                 sysSpreadWe,
  input  logic [SYS_SS_W-1:0]  sysSpreadData,
  input  logic                 pcieSpreadWe,
  input  logic [PCIE_SS_W-1:0] pcieSpreadData,
  output logic                 sampleValid,
  output logic [FREQ_W-1:0]    sysFreqCode,
  output logic                 ddrSel,
  output logic                 pcieSel,
  output logic [SYS_SS_W-1:0]  sysSpreadCode,
  output logic [PCIE_SS_W-1:0] pcieSpreadCode
);
  cfgStrobe_t stb;
  logic sysLocked;
  logic pcieLocked;

  clk_mode_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .freqWe(freqWe),
    .sysSpreadWe(sysSpreadWe), .sysSpreadData(sysSpreadData),
    .pcieSpreadWe(pcieSpreadWe), .pcieSpreadData(pcieSpreadData),
    .sysLocked(sysLocked), .pcieLocked(pcieLocked),
    .stb(stb), .sampleValid(sampleValid)
  );

  clk_mode_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .strapFs(strapFs), .strapDdrSel(strapDdrSel), .strapPcieSel(strapPcieSel),
    .freqData(freqData), .sysSpreadData(sysSpreadData), .pcieSpreadData(pcieSpreadData),
    .sysLocked(sysLocked), .pcieLocked(pcieLocked),
    .sysFreqCode(sysFreqCode), .ddrSel(ddrSel), .pcieSel(pcieSel),
    .sysSpreadCode(sysSpreadCode), .pcieSpreadCode(pcieSpreadCode)
  );
endmodule

// File: tb/tb_clk_mode_decode.sv
module tb_clk_mode_decode;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] strapFs = 2'b11;
  logic strapDdrSel = 1'b1, strapPcieSel = 1'b1;
  logic freqWe = 1'b0;
  logic [1:0] freqData = '0;
  logic sysSpreadWe = 1'b0;
  logic [2:0] sysSpreadData = '0;
  logic pcieSpreadWe = 1'b0;
  logic [1:0] pcieSpreadData = '0;
  logic sampleValid, ddrSel, pcieSel;
  logic [1:0] sysFreqCode, pcieSpreadCode;
  logic [2:0] sysSpreadCode;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_mode_decode dut (
    .clk(clk), .rstN(rstN), .strapFs(strapFs), .strapDdrSel(strapDdrSel),
    .strapPcieSel(strapPcieSel), .freqWe(freqWe), .freqData(freqData),
    .sysSpreadWe(sysSpreadWe), .sysSpreadData(sysSpreadData),
    .pcieSpreadWe(pcieSpreadWe), .pcieSpreadData(pcieSpreadData),
    .sampleValid(sampleValid), .sysFreqCode(sysFreqCode), .ddrSel(ddrSel),
    .pcieSel(pcieSel), .sysSpreadCode(sysSpreadCode), .pcieSpreadCode(pcieSpreadCode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset with given straps; optionally hold a conflicting override across capture.
  task automatic doReset(input logic [3:0] s, input logic collide);
    @(negedge clk);
    rstN = 1'b0;
    strapFs = s[1:0]; strapDdrSel = s[2]; strapPcieSel = s[3];
    freqWe = collide; freqData = ~s[1:0];
    @(negedge clk);
    check("R1 valid", int'(sampleValid), 0);
    check("R1 freq", int'(sysFreqCode), 3);
    check("R1 ddr/pcie", int'({ddrSel, pcieSel}), 3);
    check("R11 spreads", int'({sysSpreadCode, pcieSpreadCode}), 0);
    rstN = 1'b1;
    @(negedge clk);
    freqWe = 1'b0;
    check("R2 valid", int'(sampleValid), 1);
    check(collide ? "R5 capture wins" : "R2 freq", int'(sysFreqCode), int'(s[1:0]));
    check("R6 ddrSel", int'(ddrSel), int'(s[2]));
    check("R6 pcieSel", int'(pcieSel), int'(s[3]));
    strapFs = ~s[1:0]; strapDdrSel = ~s[2]; strapPcieSel = ~s[3];
    @(negedge clk);
    check("R2 valid falls", int'(sampleValid), 0);
    check("R3 straps ignored", int'({sysFreqCode, ddrSel, pcieSel}), int'({s[1:0], s[2], s[3]}));
  endtask

  task automatic wrSys(input logic [2:0] v);
    sysSpreadWe = 1'b1; sysSpreadData = v;
    @(negedge clk);
    sysSpreadWe = 1'b0;
  endtask

  task automatic wrPcie(input logic [1:0] v);
    pcieSpreadWe = 1'b1; pcieSpreadData = v;
    @(negedge clk);
    pcieSpreadWe = 1'b0;
  endtask

  function automatic logic spreads(input logic [1:0] c);
    return c == 2'b01 || c == 2'b10;
  endfunction

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R2 R3 R6: every strap combination, with and without a colliding write (R5)
    for (int s = 0; s < 16; s++) begin
      doReset(4'(s), 1'b0);
      doReset(4'(s), 1'b1);
    end
    // R4: override every code over every strap frequency
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        doReset({2'b11, 2'(s)}, 1'b0);
        freqWe = 1'b1; freqData = 2'(w);
        @(negedge clk);
        freqWe = 1'b0;
        check("R4 override", int'(sysFreqCode), w);
      end
    end
    // R7 R8: all ordered pairs of system spread writes
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        doReset(4'b1111, 1'b0);
        wrSys(3'(a));
        check("R7 sys write", int'(sysSpreadCode), a);
        wrSys(3'(b));
        check("R8 sys lock", int'(sysSpreadCode), (a != 0 && b == 0) ? a : b);
      end
    end
    // R9 R10: all ordered PCIe pairs at both PCIe frequencies
    for (int sel = 0; sel < 2; sel++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          int st;
          doReset({1'(sel), 3'b111}, 1'b0);
          wrPcie(2'(a));
          check("R10 pcie first", int'(pcieSpreadCode), sel ? a : 0);
          wrPcie(2'(b));
          st = (spreads(2'(a)) && !spreads(2'(b))) ? a : b;
          check(sel ? "R9 pcie lock" : "R10 pcie forced off", int'(pcieSpreadCode), sel ? st : 0);
        end
      end
    end
    // R11: reset releases a locked domain
    doReset(4'b1111, 1'b0);
    wrSys(3'd5);
    wrPcie(2'd2);
    doReset(4'b1111, 1'b0);
    wrSys(3'd0);
    wrPcie(2'd3);
    check("R11 sys unlocked", int'(sysSpreadCode), 0);
    check("R11 pcie unlocked", int'(pcieSpreadCode), 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule